// File: doc/BRIEF.md
# Input-Rail Pulse-Frequency Buck Controller

This block is the digital timing core for a synchronous buck converter that runs in discontinuous conduction and whose job is to hold its *input* rail down at a target level, not to regulate an output. A divided copy of the input rail is compared against a reference by an external clocked comparator. Once per converter tick, the block looks at that comparator bit. When the rail is above target, it asks for a shared inductor. It waits for the grant, then fires one energy pulse: the high-side gate for a fixed count of delay units, one dead cycle, the low-side gate for a count taken from a table, one more dead cycle, and a single-cycle release of the inductor.

The loop is open. No current sensing is done. Zero-current switching comes from the ratio of the two on-times. The low-side on-time for a 4-bit input-voltage setpoint is computed as Tls = Ths x (Vin - 1.8 V) / 1.8 V. Code k stands for Vin = 2.2 V + k x 2.8 V / 15. Because only the ratio matters, one delay unit is simply one system clock. The converter tick is produced by dividing the system clock.

The inductor request behaves like a valid signal under back-pressure. Once raised, it stays high until the grant is seen, and the grant plays the role of ready. Gate enables and the release strobe are plain control pins.

Top module: `pfm_buck_ctrl`

## Requirements
- R1: While reset is asserted, and directly after it, the request, release, high-side and low-side outputs are all low.
- R2: If the comparator bit is low on a converter tick, no request is raised and both gates stay off.
- R3: The comparator is sampled only on converter ticks, which come once every TICK_DIV clocks. With the comparator held high, the grant given at once, and every pulse finishing inside one period, successive request rising edges lie exactly TICK_DIV clocks apart.
- R4: A raised request stays high until the grant is sampled. It is low in the following cycle, and the high-side gate turns on in that same cycle.
- R5: The high-side gate stays on for exactly HS_UNITS consecutive clocks.
- R6: The low-side gate stays on for round(HS_UNITS x (Vin - 1.8) / 1.8) clocks, with a minimum of 1. Here Vin = 2.2 + k x 2.8 / 15 volts for setpoint code k (0 to 15).
- R7: The two gates are never on together. Exactly one cycle with both gates off lies between the high-side turning off and the low-side turning on.
- R8: After the low-side turns off, exactly one cycle has everything off. Then the release is high for exactly one cycle, and the block goes back to idle.
- R9: The setpoint is captured when the grant is taken. Changing it later in the pulse does not change that pulse's low-side on-time.
- R10: A converter tick issues at most one pulse. From a request until its release, no further request edge appears, even if ticks pass while the grant is delayed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock; one delay unit |
| rst_n | input | 1 | Active-low synchronous reset |
| cmp_above_i | input | 1 | Clocked comparator: divided input rail above reference |
| vset_i | input | 4 | Input-voltage setpoint code |
| ind_req_o | output | 1 | Shared-inductor request, held until grant |
| ind_ack_i | input | 1 | Shared-inductor grant |
| ind_rel_o | output | 1 | One-cycle inductor release strobe |
| hs_gate_o | output | 1 | High-side switch enable |
| ls_gate_o | output | 1 | Low-side switch enable |

## Verification
The assertions assume three things about the inputs. The comparator bit and the setpoint are synchronous to the clock. The arbiter grants only while a request is pending. A grant is a single-cycle pulse. The stimulus meets these terms. It drives every input on the falling edge. Its grant responder raises the grant for one cycle only after it has seen the request high, and waits a chosen number of cycles first, ranging from none to more than two converter periods. Setpoint changes in the middle of a pulse are made only after the grant, to check that the value was captured then.

// File: rtl/pfm_pkg.sv
package pfm_pkg;

  typedef enum logic [2:0] {
    PH_IDLE,
    PH_WAIT,
    PH_HIGH,
    PH_GAP_A,
    PH_LOW,
    PH_GAP_B,
    PH_FREE
  } pfm_phase_e;

  // Low-side units for code k over `steps` setpoint steps spanning 2.2..5.0 V:
  // round(hs * (Vin - 1.8) / 1.8), with Vin in mV scaled by `steps`.
  function automatic int low_units(int hs, int code, int steps);
    int n;
    n = (hs * (400 * steps + 2800 * code) + 900 * steps) / (1800 * steps);
    if (n < 1) n = 1;
    return n;
  endfunction

endpackage

// File: rtl/pfm_tick_div.sv
module pfm_tick_div #(
  parameter int DIV = 6250
) (
  input  logic clk,
  input  logic rst_n,
  output logic tick_o
);
  localparam int W = (DIV > 1) ? $clog2(DIV) : 1;
  localparam logic [W-1:0] LAST = W'(DIV - 1);

  logic [W-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (!rst_n)             cnt_q <= '0;
    else if (cnt_q == LAST) cnt_q <= '0;
    else                    cnt_q <= cnt_q + 1'b1;
  end

  assign tick_o = (cnt_q == LAST);

  AST_TICK_SPACED: assert property (@(posedge clk) disable iff (!rst_n)
    tick_o |=> !tick_o); // R3

endmodule

// File: rtl/pfm_ontime_lut.sv
module pfm_ontime_lut #(
  parameter int HS_UNITS = 8,
  parameter int SP_W     = 4,
  parameter int CNT_W    = 5
) (
  input  logic [SP_W-1:0]  code_i,
  output logic [CNT_W-1:0] units_o
);
  localparam int ENTRIES = 1 << SP_W;

  logic [CNT_W-1:0] table_w [ENTRIES];

  for (genvar g = 0; g < ENTRIES; g++) begin : g_entry
    assign table_w[g] = CNT_W'(pfm_pkg::low_units(HS_UNITS, g, ENTRIES - 1));
  end

  assign units_o = table_w[code_i];

endmodule

// File: rtl/pfm_pulse_fsm.sv
module pfm_pulse_fsm #(
  parameter int HS_UNITS = 8,
  parameter int SP_W     = 4,
  parameter int CNT_W    = 5
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tick_i,
  input  logic             cmp_i,
  input  logic [SP_W-1:0]  vset_i,
  input  logic             ack_i,
  input  logic [CNT_W-1:0] ls_units_i,
  output logic [SP_W-1:0]  code_o,
  output logic             req_o,
  output logic             rel_o,
  output logic             hs_o,
  output logic             ls_o
);
  import pfm_pkg::*;

  localparam logic [CNT_W-1:0] HS_LOAD = CNT_W'(HS_UNITS - 1);

  pfm_phase_e       ph_q, ph_d;
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic [SP_W-1:0]  code_q;

  always_comb begin
    ph_d  = ph_q;
    cnt_d = cnt_q;
    unique case (ph_q)
      PH_IDLE:  if (tick_i && cmp_i) ph_d = PH_WAIT;
      PH_WAIT:  if (ack_i) begin ph_d = PH_HIGH; cnt_d = HS_LOAD; end
      PH_HIGH:  if (cnt_q == '0) ph_d = PH_GAP_A; else cnt_d = cnt_q - 1'b1;
      PH_GAP_A: begin ph_d = PH_LOW; cnt_d = ls_units_i - 1'b1; end
      PH_LOW:   if (cnt_q == '0) ph_d = PH_GAP_B; else cnt_d = cnt_q - 1'b1;
      PH_GAP_B: ph_d = PH_FREE;
      PH_FREE:  ph_d = PH_IDLE;
      default:  ph_d = PH_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ph_q   <= PH_IDLE;
      cnt_q  <= '0;
      code_q <= '0;
      req_o  <= 1'b0;
      rel_o  <= 1'b0;
      hs_o   <= 1'b0;
      ls_o   <= 1'b0;
    end else begin
      ph_q  <= ph_d;
      cnt_q <= cnt_d;
      if (ph_q == PH_WAIT && ack_i) code_q <= vset_i;
      req_o <= (ph_d == PH_WAIT);
      rel_o <= (ph_d == PH_FREE);
      hs_o  <= (ph_d == PH_HIGH);
      ls_o  <= (ph_d == PH_LOW);
    end
  end

  assign code_o = code_q;

  AST_GATES_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rst_n)
    !(hs_o && ls_o)); // R7
  AST_DEAD_AFTER_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(hs_o) |-> !ls_o); // R7
  AST_REQ_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    (req_o && !ack_i) |=> req_o); // R4
  AST_REQ_FROM_TICK: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(req_o) |-> $past(tick_i && cmp_i)); // R3
  AST_REQ_GATES_OFF: assert property (@(posedge clk) disable iff (!rst_n)
    req_o |-> (!hs_o && !ls_o && !rel_o)); // R10
  AST_REL_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    rel_o |=> !rel_o); // R8
  AST_REL_AFTER_GAP: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rel_o) |-> (!ls_o && !$past(ls_o))); // R8

endmodule

// File: rtl/pfm_buck_ctrl.sv
module pfm_buck_ctrl #(
  parameter int TICK_DIV = 6250,
  parameter int HS_UNITS = 8,
  parameter int SP_W     = 4
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            cmp_above_i,
  input  logic [SP_W-1:0] vset_i,
  output logic            ind_req_o,
  input  logic            ind_ack_i,
  output logic            ind_rel_o,
  output logic            hs_gate_o,
  output logic            ls_gate_o
);
  localparam int CNT_W = $clog2(2 * HS_UNITS + 1);

  logic             tick_w;
  logic [SP_W-1:0]  code_w;
  logic [CNT_W-1:0] ls_units_w;

  pfm_tick_div #(.DIV(TICK_DIV)) u_tick (
    .clk    (clk),
    .rst_n  (rst_n),
    .tick_o (tick_w)
  );

  pfm_ontime_lut #(.HS_UNITS(HS_UNITS), .SP_W(SP_W), .CNT_W(CNT_W)) u_lut (
    .code_i  (code_w),
    .units_o (ls_units_w)
  );

  pfm_pulse_fsm #(.HS_UNITS(HS_UNITS), .SP_W(SP_W), .CNT_W(CNT_W)) u_fsm (
    .clk        (clk),
    .rst_n      (rst_n),
    .tick_i     (tick_w),
    .cmp_i      (cmp_above_i),
    .vset_i     (vset_i),
    .ack_i      (ind_ack_i),
    .ls_units_i (ls_units_w),
    .code_o     (code_w),
    .req_o      (ind_req_o),
    .rel_o      (ind_rel_o),
    .hs_o       (hs_gate_o),
    .ls_o       (ls_gate_o)
  );

endmodule

// File: tb/pfm_buck_ctrl_bench.sv
module pfm_buck_ctrl_bench;
  localparam int TDIV = 64;
  localparam int HSU  = 8;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cmp = 1'b0;
  logic [3:0] vset = 4'd0;
  logic ack = 1'b0;
  logic req, rel, hs, ls;

  int total = 0, bad = 0;
  int cyc = 0, req_rises = 0, done_cnt = 0;
  int ack_dly = 0;
  int exp_hs_q[$], exp_ls_q[$];

  always #4 clk = ~clk;

  pfm_buck_ctrl #(.TICK_DIV(TDIV), .HS_UNITS(HSU), .SP_W(4)) u_pfm_buck_ctrl (
    .clk(clk), .rst_n(rst_n), .cmp_above_i(cmp), .vset_i(vset),
    .ind_req_o(req), .ind_ack_i(ack), .ind_rel_o(rel),
    .hs_gate_o(hs), .ls_gate_o(ls));

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d (cycle %0d)", tag, act, exp, cyc);
    end
  endtask

  function automatic int exp_ls(input int code);
    real v, t;
    int r;
    v = 2.2 + code * 2.8 / 15.0;
    t = HSU * (v - 1.8) / 1.8;
    r = $rtoi(t + 0.5);
    if (r < 1) r = 1;
    return r;
  endfunction

  // grant responder
  initial begin
    forever begin
      @(negedge clk);
      if (rst_n && req) begin
        for (int k = 0; k < ack_dly; k++) begin
          @(negedge clk);
          check(req == 1'b1, "R4 request held while waiting", int'(req), 1);
        end
        ack = 1'b1;
        @(negedge clk);
        ack = 1'b0;
        check(req == 1'b0, "R4 request drops after grant", int'(req), 0);
        check(hs == 1'b1, "R4 high side starts after grant", int'(hs), 1);
      end
    end
  end

  // monitor / scoreboard
  initial begin
    int phase, hw, g1, lw, g2, relw;
    bit prev_req, overlap;
    phase = 0; hw = 0; g1 = 0; lw = 0; g2 = 0; relw = 0;
    prev_req = 0; overlap = 0;
    forever begin
      @(negedge clk);
      cyc++;
      if (!rst_n) continue;
      if (req && !prev_req) req_rises++;
      prev_req = req;
      if (hs && ls) overlap = 1;
      if (rel) relw++;
      else if (relw != 0) begin
        check(relw == 1, "R8 release width", relw, 1);
        relw = 0;
      end
      case (phase)
        0: if (hs) begin phase = 1; hw = 1; end
        1: if (hs) hw++;
           else if (ls) begin g1 = 0; phase = 3; lw = 1; end
           else begin g1 = 1; phase = 2; end
        2: if (ls) begin phase = 3; lw = 1; end else g1++;
        3: if (ls) lw++;
           else begin g2 = 0; phase = 4; end
        default: ;
      endcase
      if (phase == 4) begin
        if (rel) begin
          int eh, el;
          eh = exp_hs_q.pop_front();
          el = exp_ls_q.pop_front();
          check(hw == eh, "R5 high-side width", hw, eh);
          check(lw == el, "R6/R9 low-side width", lw, el);
          check(g1 == 1, "R7 dead cycles high->low", g1, 1);
          check(!overlap, "R7 gates overlap", int'(overlap), 0);
          check(g2 == 1, "R8 idle cycles low->release", g2, 1);
          overlap = 0;
          phase = 0;
          done_cnt++;
        end else g2++;
      end
    end
  end

  task automatic wait_req_rise();
    while (req) @(negedge clk);
    while (!req) @(negedge clk);
  endtask

  task automatic wait_done(input int tgt);
    while (done_cnt < tgt) @(negedge clk);
  endtask

  task automatic pulse(input logic [3:0] sp, input int dly, input logic [3:0] late);
    int tgt;
    tgt = done_cnt + 1;
    ack_dly = dly;
    vset = sp;
    cmp = 1'b1;
    wait_req_rise();
    cmp = 1'b0;
    exp_hs_q.push_back(HSU);
    exp_ls_q.push_back(exp_ls(sp));
    if (late != sp) begin
      while (!hs) @(negedge clk);
      vset = late;
    end
    wait_done(tgt);
    repeat (3) @(negedge clk);
  endtask

  initial begin
    int t0, base;
    int times[4];
    // R1 reset
    repeat (5) @(negedge clk);
    check({req, rel, hs, ls} == 4'b0, "R1 outputs in reset", int'({req, rel, hs, ls}), 0);
    rst_n = 1'b1;
    @(negedge clk);
    check({req, rel, hs, ls} == 4'b0, "R1 outputs after reset", int'({req, rel, hs, ls}), 0);

    // R2 comparator low: nothing happens
    base = req_rises;
    repeat (3 * TDIV) begin
      @(negedge clk);
      if (hs || ls) check(0, "R2 gate on with comparator low", 1, 0);
    end
    check(req_rises == base, "R2 requests with comparator low", req_rises - base, 0);

    // R6 all setpoints, various grant delays
    for (int k = 0; k < 16; k++) pulse(4'(k), (k % 4) * 3, 4'(k));

    // R9 setpoint change after grant
    pulse(4'd2, 1, 4'd14);
    pulse(4'd13, 0, 4'd0);

    // R3 tick spacing with comparator held high
    ack_dly = 0;
    vset = 4'd7;
    base = done_cnt;
    cmp = 1'b1;
    for (int i = 0; i < 4; i++) begin
      wait_req_rise();
      times[i] = cyc;
      exp_hs_q.push_back(HSU);
      exp_ls_q.push_back(exp_ls(7));
    end
    cmp = 1'b0;
    for (int i = 1; i < 4; i++)
      check(times[i] - times[i-1] == TDIV, "R3 request spacing", times[i] - times[i-1], TDIV);
    wait_done(base + 4);
    repeat (2 * TDIV) @(negedge clk);

    // R10 long grant delay spanning several ticks, comparator kept high
    base = req_rises;
    t0 = done_cnt;
    ack_dly = 150;
    vset = 4'd9;
    cmp = 1'b1;
    wait_req_rise();
    exp_hs_q.push_back(HSU);
    exp_ls_q.push_back(exp_ls(9));
    wait_done(t0 + 1);
    cmp = 1'b0;
    check(req_rises - base == 1, "R10 one request per pulse", req_rises - base, 1);
    repeat (TDIV + 4) @(negedge clk);

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    total++;
    bad++;
    $display("FAIL watchdog expired actual=%0d expected=%0d", cyc, 0);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule